// File: doc/BRIEF.md
# Square Tone Channel with Sweep

This block generates a square-wave tone whose amplitude is a 4-bit digital sample. Software programs it through a small write port with three selectable control words. One word sets up the frequency sweep. One holds the duty code, the envelope and the length. The third carries the 11-bit rate, a timed-mode bit and a trigger bit. Writing the third word with its trigger bit set starts the channel, or restarts it if it is already playing.

Four single-cycle enable strobes from a shared timing source pace the block. The base tick drives the waveform period counter. The other three strobes step the sweep unit, the volume envelope and the length counter. The waveform has eight phases, and each phase lasts `2048 - rate` base ticks, so the tone frequency is the base tick rate divided by `8 * (2048 - rate)`.

The sweep can raise the rate until it overflows, which stops the channel. It can also lower the rate. The envelope ramps the volume up or down one step at a time and holds it at either end of its range. In timed mode the length counter silences the channel once it runs out. Setting `HAS_SWEEP` to 0 builds the block without the sweep unit. Leaving the sweep shift at zero gives the same behaviour at run time.

Top module: `sq_tone_chan`

## Requirements
- R1: After reset, `active` is 0 and `amp_out` is 0.
- R2: A write with `wr_sel`=2 and `wr_data[15]`=1 sets `active` on the next cycle. It also does the following: it loads the period counter from `wr_data[10:0]`, resets the waveform phase to 0, loads the envelope volume from the initial-volume field, reloads the sweep and envelope step counters, and loads the length counter with 64 minus the length field. On that cycle the trigger takes priority over every tick.
- R3: The period counter counts base ticks up from the rate and wraps at 2047. On each wrap it reloads the current rate and advances the 3-bit phase by one, so each phase lasts 2048 - rate ticks.
- R4: The duty code, bits [7:6] of the `wr_sel`=1 word, sets the first high phase. Codes 0, 1, 2 and 3 make the wave high from phase 7, 6, 4 and 2 respectively, giving 1/8, 2/8, 4/8 and 6/8 of the waveform.
- R5: `amp_out` equals the envelope volume while `active` is 1 and the wave is high. Otherwise it is 0.
- R6: The `wr_sel`=1 word holds the length in [5:0], the envelope step count in [10:8], the direction in [11] (1 = up) and the initial volume in [15:12]. With a nonzero step count N, every N-th `env_tick` changes the volume by one in the chosen direction. The volume holds at 0 and at 15. A step count of 0 freezes the volume.
- R7: The `wr_sel`=0 word holds the shift in [2:0], the direction in [3] (1 = down) and the sweep time T in [6:4]. With T nonzero, every T-th `sweep_tick` replaces the rate with rate + (rate >> shift), or with rate - (rate >> shift) when sweeping down. A sweep time of 0 or a shift of 0 leaves the rate unchanged.
- R8: An upward sweep step whose result would exceed 2047 clears `active` and keeps the old rate.
- R9: When the timed bit (`wr_data[14]` of the `wr_sel`=2 word) is 1, each `len_tick` decrements a nonzero length counter, and `active` clears when the counter reaches 0.
- R10: When the timed bit is 0, the length counter is frozen and never clears `active`.
- R11: A `wr_sel`=2 write with the trigger bit at 0 replaces the current rate without restarting anything. If a sweep step falls in the same cycle, the written rate wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_sel | input | 2 | Word select: 0 sweep, 1 duty/envelope/length, 2 rate/control |
| wr_data | input | 16 | Control word value |
| tick_en | input | 1 | Base tick for the period counter |
| sweep_tick | input | 1 | Sweep step strobe |
| env_tick | input | 1 | Envelope step strobe |
| len_tick | input | 1 | Length step strobe |
| amp_out | output | 4 | Digital amplitude |
| active | output | 1 | Channel playing flag |

## Verification
The bench builds the block with its default parameters: an 11-bit rate, a 3-bit phase, a 6-bit length and the sweep unit present. Rates close to 2047 make a whole waveform last only 16 to 64 cycles. That makes every duty code and the exact period measurable by counting high cycles in a short window. It also lets a two-step upward sweep from 1000 reach overflow within a few dozen cycles, and lets a length of 60 expire after four ticks. A long randomised run mixes writes, retriggers and all four strobes, which brings same-cycle collisions within reach: a trigger against a tick, and a rate write against a sweep step.

// File: rtl/sq_pkg.sv
package sq_pkg;

   typedef enum logic [1:0] {
      SEL_SWEEP = 2'd0,
      SEL_TONE  = 2'd1,
      SEL_FREQ  = 2'd2
   } sq_sel_e;

   // first high phase for each duty code, for a wave of 2**phase_w phases
   function automatic int unsigned duty_first_high(input logic [1:0] code, input int unsigned phase_w);
      int unsigned n;
      n = 1 << phase_w;
      case (code)
         2'd0:    return n - n / 8;
         2'd1:    return n - n / 4;
         2'd2:    return n / 2;
         default: return n / 4;
      endcase
   endfunction

endpackage

// File: rtl/sq_period_gen.sv
module sq_period_gen
   import sq_pkg::*;
#(
   parameter int RATE_W  = 11,
   parameter int PHASE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [RATE_W-1:0] load_rate,
   input  logic              tick,
   input  logic [RATE_W-1:0] cur_rate,
   input  logic [1:0]        duty,
   output logic              wave_hi
);
   localparam logic [RATE_W-1:0] CNT_TOP = {RATE_W{1'b1}};

   logic [RATE_W-1:0]  cnt_q;
   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] first_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= '0;
      end else if (restart) begin
         cnt_q   <= load_rate;
         phase_q <= '0;
      end else if (tick) begin
         if (cnt_q == CNT_TOP) begin
            cnt_q   <= cur_rate;
            phase_q <= phase_q + 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb first_hi = PHASE_W'(duty_first_high(duty, PHASE_W));
   assign wave_hi = (phase_q >= first_hi);

endmodule

// File: rtl/sq_sweep.sv
module sq_sweep #(
   parameter int RATE_W    = 11,
   parameter int SHIFT_W   = 3,
   parameter int TIME_W    = 3,
   parameter bit HAS_SWEEP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rate_wr,
   input  logic [RATE_W-1:0]  rate_in,
   input  logic               restart,
   input  logic               step_tick,
   input  logic [SHIFT_W-1:0] shift,
   input  logic               dir_down,
   input  logic [TIME_W-1:0]  period,
   output logic [RATE_W-1:0]  cur_rate,
   output logic               overflow
);
   logic [RATE_W-1:0] rate_q;
   assign cur_rate = rate_q;

   if (HAS_SWEEP) begin : g_sweep
      logic [TIME_W-1:0] div_q;
      logic [RATE_W-1:0] delta;
      logic [RATE_W:0]   sum;
      logic [RATE_W-1:0] diff;
      logic              fire;
      logic              apply;

      assign delta = rate_q >> shift;
      assign sum   = {1'b0, rate_q} + {1'b0, delta};
      assign diff  = rate_q - delta;
      assign fire  = step_tick && (period != '0) && (div_q <= TIME_W'(1)) && !restart;
      assign apply = fire && (shift != '0);
      assign overflow = apply && !dir_down && sum[RATE_W];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rate_q <= '0;
            div_q  <= '0;
         end else begin
            if (restart) div_q <= period;
            else if (step_tick && (period != '0))
               div_q <= (div_q <= TIME_W'(1)) ? period : div_q - 1'b1;

            if (restart || rate_wr) rate_q <= rate_in;
            else if (apply && dir_down) rate_q <= diff;
            else if (apply && !sum[RATE_W]) rate_q <= sum[RATE_W-1:0];
         end
      end
   end else begin : g_fixed
      logic unused_sweep_in;
      assign unused_sweep_in = ^{step_tick, shift, dir_down, period};
      assign overflow = 1'b0;

      always_ff @(posedge clk) begin
         if (!rst_n) rate_q <= '0;
         else if (restart || rate_wr) rate_q <= rate_in;
      end
   end

endmodule

// File: rtl/sq_envelope.sv
module sq_envelope #(
   parameter int VOL_W  = 4,
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              tick,
   input  logic [VOL_W-1:0]  init_vol,
   input  logic [STEP_W-1:0] step,
   input  logic              up,
   output logic [VOL_W-1:0]  vol
);
   localparam logic [VOL_W-1:0] VOL_MAX = {VOL_W{1'b1}};

   logic [STEP_W-1:0] div_q;
   logic [VOL_W-1:0]  vol_q;
   assign vol = vol_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vol_q <= '0;
         div_q <= '0;
      end else if (restart) begin
         vol_q <= init_vol;
         div_q <= step;
      end else if (tick && (step != '0)) begin
         if (div_q <= STEP_W'(1)) begin
            div_q <= step;
            if (up && (vol_q != VOL_MAX)) vol_q <= vol_q + 1'b1;
            else if (!up && (vol_q != '0)) vol_q <= vol_q - 1'b1;
         end else begin
            div_q <= div_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/sq_length.sv
module sq_length #(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic             timed,
   input  logic [LEN_W-1:0] len_field,
   output logic             expire
);
   localparam int CNT_W = LEN_W + 1;
   localparam logic [CNT_W-1:0] FULL = {1'b1, {LEN_W{1'b0}}};

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step   = tick && timed && (cnt_q != '0) && !restart;
   assign expire = step && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (restart) cnt_q <= FULL - {1'b0, len_field};
      else if (step) cnt_q <= cnt_q - 1'b1;
   end

endmodule

// File: rtl/sq_tone_chan.sv
module sq_tone_chan
   import sq_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int RATE_W    = 11,
   parameter int PHASE_W   = 3,
   parameter int VOL_W     = 4,
   parameter int LEN_W     = 6,
   parameter int ESTEP_W   = 3,
   parameter int SHIFT_W   = 3,
   parameter int SWTIME_W  = 3,
   parameter bit HAS_SWEEP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick_en,
   input  logic              sweep_tick,
   input  logic              env_tick,
   input  logic              len_tick,
   output logic [VOL_W-1:0]  amp_out,
   output logic              active
);
   // field layout of the duty/envelope/length word
   localparam int DUTY_LO  = LEN_W;
   localparam int ESTEP_LO = DUTY_LO + 2;
   localparam int EDIR_BIT = ESTEP_LO + ESTEP_W;
   localparam int IVOL_LO  = EDIR_BIT + 1;
   // field layout of the sweep word
   localparam int SDIR_BIT = SHIFT_W;
   localparam int STIME_LO = SDIR_BIT + 1;
   // control bits of the rate word
   localparam int TRIG_BIT  = DATA_W - 1;
   localparam int TIMED_BIT = DATA_W - 2;

   if (IVOL_LO + VOL_W > DATA_W) begin : g_bad_tone
      $error("duty/envelope/length word does not fit DATA_W");
   end
   if (STIME_LO + SWTIME_W > DATA_W) begin : g_bad_sweep
      $error("sweep word does not fit DATA_W");
   end
   if (RATE_W + 3 > DATA_W) begin : g_bad_rate
      $error("rate word needs RATE_W + 3 <= DATA_W");
   end
   if (PHASE_W < 3) begin : g_bad_phase
      $error("PHASE_W below 3 cannot express an eighth duty");
   end

   logic wr_sweep, wr_tone, wr_freq, trig;
   assign wr_sweep = wr_en && (wr_sel == SEL_SWEEP);
   assign wr_tone  = wr_en && (wr_sel == SEL_TONE);
   assign wr_freq  = wr_en && (wr_sel == SEL_FREQ);
   assign trig     = wr_freq && wr_data[TRIG_BIT];

   logic [SHIFT_W-1:0]  sw_shift_q;
   logic                sw_down_q;
   logic [SWTIME_W-1:0] sw_time_q;
   logic [LEN_W-1:0]    len_q;
   logic [1:0]          duty_q;
   logic [ESTEP_W-1:0]  estep_q;
   logic                eup_q;
   logic [VOL_W-1:0]    ivol_q;
   logic                timed_q;
   logic                active_q;

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data[TIMED_BIT-1:RATE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_shift_q <= '0;
         sw_down_q  <= 1'b0;
         sw_time_q  <= '0;
         len_q      <= '0;
         duty_q     <= '0;
         estep_q    <= '0;
         eup_q      <= 1'b0;
         ivol_q     <= '0;
         timed_q    <= 1'b0;
      end else begin
         if (wr_sweep) begin
            sw_shift_q <= wr_data[SHIFT_W-1:0];
            sw_down_q  <= wr_data[SDIR_BIT];
            sw_time_q  <= wr_data[STIME_LO +: SWTIME_W];
         end
         if (wr_tone) begin
            len_q   <= wr_data[LEN_W-1:0];
            duty_q  <= wr_data[DUTY_LO +: 2];
            estep_q <= wr_data[ESTEP_LO +: ESTEP_W];
            eup_q   <= wr_data[EDIR_BIT];
            ivol_q  <= wr_data[IVOL_LO +: VOL_W];
         end
         if (wr_freq) timed_q <= wr_data[TIMED_BIT];
      end
   end

   logic [RATE_W-1:0] cur_rate;
   logic              sweep_ovf;
   logic              len_expire;
   logic              wave_hi;
   logic [VOL_W-1:0]  env_vol;

   sq_sweep #(
      .RATE_W(RATE_W), .SHIFT_W(SHIFT_W), .TIME_W(SWTIME_W), .HAS_SWEEP(HAS_SWEEP)
   ) i_sweep (
      .clk(clk), .rst_n(rst_n),
      .rate_wr(wr_freq), .rate_in(wr_data[RATE_W-1:0]), .restart(trig),
      .step_tick(sweep_tick), .shift(sw_shift_q), .dir_down(sw_down_q),
      .period(sw_time_q), .cur_rate(cur_rate), .overflow(sweep_ovf)
   );

   sq_period_gen #(.RATE_W(RATE_W), .PHASE_W(PHASE_W)) i_period (
      .clk(clk), .rst_n(rst_n), .restart(trig), .load_rate(wr_data[RATE_W-1:0]),
      .tick(tick_en), .cur_rate(cur_rate), .duty(duty_q), .wave_hi(wave_hi)
   );

   sq_envelope #(.VOL_W(VOL_W), .STEP_W(ESTEP_W)) i_env (
      .clk(clk), .rst_n(rst_n), .restart(trig), .tick(env_tick),
      .init_vol(ivol_q), .step(estep_q), .up(eup_q), .vol(env_vol)
   );

   sq_length #(.LEN_W(LEN_W)) i_len (
      .clk(clk), .rst_n(rst_n), .restart(trig), .tick(len_tick),
      .timed(timed_q), .len_field(len_q), .expire(len_expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) active_q <= 1'b0;
      else if (trig) active_q <= 1'b1;
      else if (sweep_ovf || len_expire) active_q <= 1'b0;
   end

   assign active  = active_q;
   assign amp_out = (active_q && wave_hi) ? env_vol : '0;

endmodule

// File: rtl/sq_tone_chan_chk.sv
module sq_tone_chan_chk #(
   parameter int DATA_W = 16,
   parameter int RATE_W = 11,
   parameter int VOL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              sweep_tick,
   input logic              env_tick,
   input logic              len_tick,
   input logic [VOL_W-1:0]  amp_out,
   input logic              active,
   input logic [VOL_W-1:0]  env_vol,
   input logic [VOL_W-1:0]  ivol_q,
   input logic [RATE_W-1:0] cur_rate,
   input logic              timed_q
);
   localparam logic [VOL_W:0] ONE = (VOL_W+1)'(1);

   logic rate_wr, trig;
   logic [VOL_W:0] vol_x;
   assign rate_wr = wr_en && (wr_sel == 2'd2);
   assign trig    = rate_wr && wr_data[DATA_W-1];
   assign vol_x   = {1'b0, env_vol};

   AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n) trig |=> active); // R2
   AST_TRIG_VOLUME: assert property (@(posedge clk) disable iff (!rst_n) trig |=> (env_vol == $past(ivol_q))); // R2
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !active |-> (amp_out == '0)); // R5
   AST_AMP_IS_VOLUME: assert property (@(posedge clk) disable iff (!rst_n) (amp_out != '0) |-> (amp_out == env_vol)); // R5
   AST_ENV_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(trig) && (env_vol != $past(env_vol))) |-> $past(env_tick)); // R6
   AST_ENV_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(trig) |-> ((vol_x == $past(vol_x)) || (vol_x == $past(vol_x) + ONE) || (vol_x + ONE == $past(vol_x)))); // R6
   AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sweep_tick) && !$past(rate_wr)) |-> $stable(cur_rate)); // R7
   AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(sweep_tick || (len_tick && timed_q))); // R9
   AST_UNTIMED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !timed_q && !sweep_tick) |=> active); // R10

endmodule

bind sq_tone_chan sq_tone_chan_chk #(
   .DATA_W(DATA_W), .RATE_W(RATE_W), .VOL_W(VOL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .sweep_tick(sweep_tick), .env_tick(env_tick), .len_tick(len_tick),
   .amp_out(amp_out), .active(active), .env_vol(env_vol), .ivol_q(ivol_q),
   .cur_rate(cur_rate), .timed_q(timed_q)
);

// File: tb/test_sq_tone_chan.sv
module test_sq_tone_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        tick_en = 1'b0, sweep_tick = 1'b0, env_tick = 1'b0, len_tick = 1'b0;
   logic [3:0]  amp_out;
   logic        active;

   int checks = 0, fails = 0;
   bit done = 0;
   string cur_req = "R1";
   int div_t = 1, div_s = 0, div_e = 0, div_l = 0;
   bit rand_ticks = 0;
   int cyc = 0;

   // reference state
   int m_rate, m_cnt, m_phase, m_vol, m_ec, m_sc, m_len, m_act;
   int r_shift, r_down, r_time, r_len, r_duty, r_estep, r_eup, r_ivol, r_timed;

   sq_tone_chan i_sq_tone_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .tick_en(tick_en), .sweep_tick(sweep_tick), .env_tick(env_tick), .len_tick(len_tick),
      .amp_out(amp_out), .active(active)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic int first_high(input int d);
      case (d)
         0: return 7;
         1: return 6;
         2: return 4;
         default: return 2;
      endcase
   endfunction

   // behavioural reference, advanced on every clock, compared mid-cycle
   always @(posedge clk) begin
      if (!rst_n) begin
         m_rate = 0; m_cnt = 0; m_phase = 0; m_vol = 0; m_ec = 0; m_sc = 0; m_len = 0; m_act = 0;
         r_shift = 0; r_down = 0; r_time = 0; r_len = 0; r_duty = 0;
         r_estep = 0; r_eup = 0; r_ivol = 0; r_timed = 0;
      end else begin
         int n_rate, n_cnt, n_phase, n_vol, n_ec, n_sc, n_len, n_act, wr_rate, d;
         bit fwr, trg;
         n_rate = m_rate; n_cnt = m_cnt; n_phase = m_phase; n_vol = m_vol;
         n_ec = m_ec; n_sc = m_sc; n_len = m_len; n_act = m_act;
         fwr = wr_en && wr_sel == 2'd2;
         trg = fwr && wr_data[15];
         wr_rate = int'(wr_data[10:0]);
         if (trg) begin
            n_rate = wr_rate; n_cnt = wr_rate; n_phase = 0; n_vol = r_ivol;
            n_ec = r_estep; n_sc = r_time; n_len = 64 - r_len; n_act = 1;
         end else begin
            if (tick_en) begin
               if (m_cnt == 2047) begin n_cnt = m_rate; n_phase = (m_phase + 1) % 8; end
               else n_cnt = m_cnt + 1;
            end
            if (env_tick && r_estep != 0) begin
               if (m_ec <= 1) begin
                  n_ec = r_estep;
                  if (r_eup != 0 && m_vol < 15) n_vol = m_vol + 1;
                  else if (r_eup == 0 && m_vol > 0) n_vol = m_vol - 1;
               end else n_ec = m_ec - 1;
            end
            if (sweep_tick && r_time != 0) begin
               if (m_sc <= 1) begin
                  n_sc = r_time;
                  if (r_shift != 0) begin
                     d = m_rate >> r_shift;
                     if (r_down != 0) n_rate = m_rate - d;
                     else if (m_rate + d > 2047) n_act = 0;
                     else n_rate = m_rate + d;
                  end
               end else n_sc = m_sc - 1;
            end
            if (len_tick && r_timed != 0 && m_len != 0) begin
               n_len = m_len - 1;
               if (m_len == 1) n_act = 0;
            end
            if (fwr) n_rate = wr_rate;
         end
         if (wr_en && wr_sel == 2'd0) begin
            r_shift = int'(wr_data[2:0]); r_down = int'(wr_data[3]); r_time = int'(wr_data[6:4]);
         end
         if (wr_en && wr_sel == 2'd1) begin
            r_len = int'(wr_data[5:0]); r_duty = int'(wr_data[7:6]); r_estep = int'(wr_data[10:8]);
            r_eup = int'(wr_data[11]); r_ivol = int'(wr_data[15:12]);
         end
         if (fwr) r_timed = int'(wr_data[14]);
         m_rate = n_rate; m_cnt = n_cnt; m_phase = n_phase; m_vol = n_vol;
         m_ec = n_ec; m_sc = n_sc; m_len = n_len; m_act = n_act;
         #5;
         begin
            int exp_amp;
            exp_amp = (m_act != 0 && m_phase >= first_high(r_duty)) ? m_vol : 0;
            check({cur_req, " amp"}, int'(amp_out), exp_amp);
            check({cur_req, " active"}, int'(active), m_act);
         end
      end
   end

   // strobe generation
   always @(negedge clk) begin
      cyc++;
      if (rand_ticks) begin
         tick_en = ($urandom % 2) == 0;
         sweep_tick = ($urandom % 5) == 0;
         env_tick = ($urandom % 4) == 0;
         len_tick = ($urandom % 6) == 0;
      end else begin
         tick_en    = div_t > 0 && (cyc % div_t) == 0;
         sweep_tick = div_s > 0 && (cyc % div_s) == 0;
         env_tick   = div_e > 0 && (cyc % div_e) == 0;
         len_tick   = div_l > 0 && (cyc % div_l) == 0;
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [15:0] tone_word(input int len, input int duty, input int step, input int up, input int vol);
      return 16'(len) | 16'(duty << 6) | 16'(step << 8) | 16'(up << 11) | 16'(vol << 12);
   endfunction

   function automatic logic [15:0] freq_word(input int rate, input int timed, input int trigger);
      return 16'(rate) | 16'(timed << 14) | 16'(trigger << 15);
   endfunction

   task automatic count_high(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #5;
         if (amp_out != 0) hi++;
      end
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int hi;
      repeat (3) @(posedge clk);
      #5;
      check("R1 amp", int'(amp_out), 0);
      check("R1 active", int'(active), 0);
      @(negedge clk); rst_n = 1'b1;

      // duty codes at the shortest period (2 ticks per phase)
      cur_req = "R4";
      wr(2'd0, 16'h0000);
      for (int d = 0; d < 4; d++) begin
         wr(2'd1, tone_word(0, d, 0, 0, 15));
         wr(2'd2, freq_word(2046, 0, 1));
         wait_cycles(4);
         count_high(16, hi);
         check("R4 high cycles per wave", hi, (d == 0) ? 2 : (d == 1) ? 4 : (d == 2) ? 8 : 12);
      end

      // period length
      cur_req = "R3";
      wr(2'd1, tone_word(0, 0, 0, 0, 9));
      wr(2'd2, freq_word(2044, 0, 1));
      check("R2 active after trigger", int'(active), 1);
      wait_cycles(3);
      count_high(32, hi);
      check("R3 rate 2044 high count", hi, 4);
      wr(2'd1, tone_word(0, 2, 0, 0, 9));
      wr(2'd2, freq_word(2040, 0, 1));
      count_high(64, hi);
      check("R3 rate 2040 high count", hi, 32);

      // envelope up with saturation, then down to zero
      cur_req = "R6";
      wr(2'd1, tone_word(0, 3, 1, 1, 13));
      wr(2'd2, freq_word(2046, 0, 1));
      div_e = 2;
      wait_cycles(20);
      hi = 0;
      for (int i = 0; i < 20 && hi == 0; i++) begin
         @(posedge clk); #5;
         if (amp_out != 0) hi = int'(amp_out);
      end
      check("R6 saturates at 15", hi, 15);
      wr(2'd1, tone_word(0, 3, 2, 0, 2));
      wr(2'd2, freq_word(2046, 0, 1));
      wait_cycles(30);
      count_high(16, hi);
      check("R6 holds at 0", hi, 0);
      check("R6 still active", int'(active), 1);
      wr(2'd1, tone_word(0, 3, 0, 1, 6));
      wr(2'd2, freq_word(2046, 0, 1));
      wait_cycles(20);
      div_e = 0;

      // sweep up to overflow
      cur_req = "R8";
      wr(2'd0, 16'h0011);
      wr(2'd2, freq_word(1000, 0, 1));
      div_s = 7;
      wait_cycles(30);
      check("R8 overflow stops channel", int'(active), 0);

      // sweep down
      cur_req = "R7";
      wr(2'd0, 16'h002A);
      wr(2'd2, freq_word(1600, 0, 1));
      div_s = 3;
      wait_cycles(60);
      check("R7 down sweep keeps playing", int'(active), 1);
      wr(2'd0, 16'h0010);
      wr(2'd2, freq_word(2000, 0, 1));
      wait_cycles(30);
      check("R7 shift zero keeps playing", int'(active), 1);
      div_s = 0;

      // rate change without restart
      cur_req = "R11";
      wr(2'd2, freq_word(2030, 0, 0));
      wait_cycles(40);
      check("R11 no restart", int'(active), 1);

      // length counter
      cur_req = "R9";
      wr(2'd0, 16'h0000);
      wr(2'd1, tone_word(60, 2, 0, 0, 11));
      wr(2'd2, freq_word(2046, 1, 1));
      div_l = 3;
      wait_cycles(20);
      check("R9 timed expiry", int'(active), 0);
      cur_req = "R10";
      wr(2'd2, freq_word(2046, 0, 1));
      wait_cycles(30);
      check("R10 untimed continues", int'(active), 1);
      div_l = 0;

      // randomised mix
      cur_req = "R2";
      rand_ticks = 1;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (($urandom % 8) == 0) begin
            wr_en = 1'b1;
            wr_sel = 2'($urandom % 3);
            wr_data = 16'($urandom);
            if (wr_sel == 2'd2 && ($urandom % 3) != 0) wr_data[10:8] = 3'b111;
         end else begin
            wr_en = 1'b0;
         end
      end
      @(negedge clk); wr_en = 1'b0; rand_ticks = 0;
      wait_cycles(2);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule